// File: doc/BRIEF.md
# Write-Through Integer Register File

This block holds the general-purpose integer state of a five-stage scalar datapath. It has thirty-two registers of thirty-two bits each. Two read ports serve the decode stage. One clocked write port serves the write-back stage. Each read port takes a register index and returns its contents combinationally, within the same cycle.

A pipeline normally writes early in a cycle and reads late in that cycle. Here that timing is modelled with single-edge flip-flops. When a write is enabled in a cycle, its data is passed straight to any read port that addresses the same register in that cycle. Decode therefore sees the value that write-back is committing, and no extra forwarding path from write-back is needed. Index 0 is a constant zero. A synchronous, active-high reset clears the whole file.

Top module: `wt_regfile`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, every register becomes zero. Afterwards, every index reads 0 on both ports until it is written.
- R2: With no write forwarded to it, read port A returns the stored contents of the register at index `rd_a_sel`, combinationally in the same cycle.
- R3: Read port B behaves as in R2 for `rd_b_sel`, independently of port A. Both ports may address the same or different registers.
- R4: A register is updated only at a rising edge where `wr_en` is 1, `rst` is 0 and `wr_sel` selects it. If `wr_en` is 0, the contents are unchanged.
- R5: When `wr_en` is 1, `rst` is 0 and `wr_sel` equals a nonzero read index, that read port returns `wr_data` in the same cycle. From the following cycle it returns the stored copy of that same value.
- R6: Index 0 always reads 0 on both ports. A write to index 0 neither stores data nor is forwarded.
- R7: Forwarding needs both `wr_en` = 1 and an exact index match. A pending write to another register, or a disabled write to the same register, leaves the read value at the stored contents.
- R8: While `rst` is high, a write request is neither stored nor forwarded. Reads in that cycle return the contents as they were before the edge.
- R9: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| rd_a_sel | input | 5 | Register index for read port A |
| rd_a_data | output | 32 | Read data for port A (combinational) |
| rd_b_sel | input | 5 | Register index for read port B |
| rd_b_data | output | 32 | Read data for port B (combinational) |
| wr_en | input | 1 | Write enable, sampled at the rising edge |
| wr_sel | input | 5 | Register index for the write |
| wr_data | input | 32 | Data to write |

## Verification
The hardest cases are the ones where forwarding and storage disagree within one cycle. These are a write coinciding with a read of the same index, a write to index 0, and a write issued while reset is high. Random traffic seldom lines up the indices, so the random generator often copies the write index onto one or both read indices. Directed cycles cover the zero index, disabled writes and writes during reset. The bench samples both read ports before each edge and again on the cycle after it. This separates the forwarded value from the committed one.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DEFAULT_REGS  = 32;
  localparam int RF_DEFAULT_WIDTH = 32;

  // Index width for a file with n entries (at least one bit).
  function automatic int rf_index_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_sel,
  output logic [NUM_REGS-1:0] wr_hit
);
  // One-hot strobe per entry; entry 0 never fires, nor does anything during reset.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
    if (i == 0) begin : g_zero
      assign wr_hit[i] = 1'b0;
    end else begin : g_live
      assign wr_hit[i] = wr_en && !rst && (wr_sel == ADDR_W'(i));
    end
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0]              wr_hit,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wr_hit[i]) begin
        regs[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [NUM_REGS-1:0]             wr_hit,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_sel,
  output logic [DATA_W-1:0]               rd_data
);
  // Same-cycle forwarding: the decoded write strobe of the addressed entry
  // already excludes entry 0, disabled writes and reset cycles.
  always_comb begin
    if (wr_hit[rd_sel]) begin
      rd_data = wr_data;
    end else begin
      rd_data = regs[rd_sel];
    end
  end
endmodule

// File: rtl/wt_regfile.sv
module wt_regfile #(
  parameter int NUM_REGS = rf_pkg::RF_DEFAULT_REGS,
  parameter int DATA_W   = rf_pkg::RF_DEFAULT_WIDTH,
  localparam int ADDR_W  = rf_pkg::rf_index_bits(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a_sel,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [ADDR_W-1:0] rd_b_sel,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_sel,
  input  logic [DATA_W-1:0] wr_data
);
  logic [NUM_REGS-1:0]             wr_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  rf_write_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_hit (wr_hit)
  );

  rf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_hit  (wr_hit),
    .wr_data (wr_data),
    .regs    (regs)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_a (
    .regs    (regs),
    .wr_hit  (wr_hit),
    .wr_data (wr_data),
    .rd_sel  (rd_a_sel),
    .rd_data (rd_a_data)
  );

  rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd_b (
    .regs    (regs),
    .wr_hit  (wr_hit),
    .wr_data (wr_data),
    .rd_sel  (rd_b_sel),
    .rd_data (rd_b_data)
  );
endmodule

// File: rtl/wt_regfile_checker.sv
module wt_regfile_checker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = rf_pkg::rf_index_bits(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] rd_a_sel,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_sel,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_sel,
  input logic [DATA_W-1:0] wr_data
);
  // R6: index zero reads zero on both ports
  assert_zero_index_R6: assert property (@(posedge clk) disable iff (rst)
    ((rd_a_sel == '0) |-> (rd_a_data == '0)) and ((rd_b_sel == '0) |-> (rd_b_data == '0)));

  // R5: same-cycle forwarding on port A
  assert_forward_a_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel != '0) && (wr_sel == rd_a_sel)) |-> (rd_a_data == wr_data));

  // R5: same-cycle forwarding on port B
  assert_forward_b_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_sel != '0) && (wr_sel == rd_b_sel)) |-> (rd_b_data == wr_data));

  // R4: a committed write is visible from storage on the next cycle
  assert_commit_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && ($past(wr_sel) != '0) && (rd_a_sel == $past(wr_sel))
     && !(wr_en && (wr_sel == rd_a_sel)))
    |-> (rd_a_data == $past(wr_data)));

  // R7: with no write enabled, the read value is stable over a held index
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && !wr_en && $stable(rd_b_sel)) |-> $stable(rd_b_data));

  // R1: the cycle after reset, both ports read zero when no write is pending
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !wr_en) |-> ((rd_a_data == '0) && (rd_b_data == '0)));
endmodule

bind wt_regfile wt_regfile_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_a_sel  (rd_a_sel),
  .rd_a_data (rd_a_data),
  .rd_b_sel  (rd_b_sel),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data)
);

// File: tb/wt_regfile_bench.sv
module wt_regfile_bench;
  localparam int NR = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] rd_a_sel, rd_b_sel, wr_sel;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data;
  logic          wr_en;

  logic [DW-1:0] model [NR];
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wt_regfile u_wt_regfile (
    .clk(clk), .rst(rst),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] s);
    if (s == '0) return '0;
    if (wr_en && !rst && (wr_sel == s)) return wr_data;
    return model[s];
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Sample both ports mid-cycle, then apply the edge to the model.
  task automatic step(input string tag_a, input string tag_b);
    #1;
    check(tag_a, rd_a_data, expect_read(rd_a_sel));
    check(tag_b, rd_b_data, expect_read(rd_b_sel));
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < NR; i++) model[i] = '0;
    end else if (wr_en && wr_sel != '0) begin
      model[wr_sel] = wr_data;
    end
    @(negedge clk);
  endtask

  task automatic drive(input logic r, input logic we, input logic [AW-1:0] ws,
                       input logic [DW-1:0] wd, input logic [AW-1:0] ra, input logic [AW-1:0] rb);
    rst = r; wr_en = we; wr_sel = ws; wr_data = wd; rd_a_sel = ra; rd_b_sel = rb;
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog timeout");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NR; i++) model[i] = 'x;
    drive(1'b1, 1'b0, '0, '0, '0, '0);
    repeat (2) @(posedge clk);
    for (int i = 0; i < NR; i++) model[i] = '0;
    @(negedge clk);

    // R1: every index reads zero after reset
    for (int i = 0; i < NR; i++) begin
      drive(1'b0, 1'b0, '0, '0, AW'(i), AW'(NR - 1 - i));
      step("R1 port A", "R1 port B");
    end

    // R5: same-cycle forwarding, then stored copy (R2, R3)
    drive(1'b0, 1'b1, 5'd5, 32'hA5A5_1234, 5'd5, 5'd5);
    step("R5 port A", "R5 port B");
    drive(1'b0, 1'b0, 5'd5, 32'h0, 5'd5, 5'd5);
    step("R2 stored", "R3 stored");

    // R7: disabled write to the read index is not forwarded; R4 not stored
    drive(1'b0, 1'b0, 5'd7, 32'hDEAD_BEEF, 5'd7, 5'd5);
    step("R7 disabled", "R3 other");
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd7, 5'd7);
    step("R4 not stored", "R4 not stored");

    // R6: write to index zero
    drive(1'b0, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0);
    step("R6 forward", "R6 forward");
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    step("R6 stored", "R6 stored");

    // R7 / R9: write to 9 while A reads 10, B reads 9
    drive(1'b0, 1'b1, 5'd9, 32'h0909_0909, 5'd10, 5'd9);
    step("R7 mismatch", "R5 match");
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd8, 5'd10);
    step("R9 neighbour", "R9 neighbour");
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd5, 5'd9);
    step("R9 kept", "R9 kept");

    // R8: write during reset, then all cleared
    drive(1'b1, 1'b1, 5'd3, 32'h3333_3333, 5'd3, 5'd9);
    step("R8 no forward", "R8 old value");
    drive(1'b0, 1'b0, 5'd0, 32'h0, 5'd3, 5'd9);
    step("R8 not stored", "R1 cleared");

    // Random traffic with index aliasing
    for (int n = 0; n < 600; n++) begin
      logic r, we;
      logic [AW-1:0] ws, ra, rb;
      r  = ($urandom_range(0, 59) == 0);
      we = $urandom_range(0, 1);
      ws = AW'($urandom);
      ra = ($urandom_range(0, 3) == 0) ? ws : AW'($urandom);
      rb = ($urandom_range(0, 3) == 0) ? ws : AW'($urandom);
      drive(r, we, ws, $urandom, ra, rb);
      step("R2 random", "R3 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule